// File: doc/BRIEF.md
# NOR Flash Bank Erase/Program Sequencer

This block runs an 8-bit asynchronous parallel NOR flash through its unlock-prefixed command protocol on behalf of a host. One start pulse launches either a sector erase of one bank or a byte-by-byte program of a whole bank. Each flash operation is followed by completion polling: the bank base is read twice in a row until the two values agree. After that a reset command goes out and the whole bank is read back and compared against the expected contents.

While programming, the host supplies the bytes through a valid/ready source. Each accepted byte is also kept in an internal buffer, which the read-back pass compares against. Strobe widths, the settling gap after each write, the read access time and the poll-attempt limit are parameters counted in clock cycles. Completion is reported with a one-cycle done pulse and a two-bit result code.

Top module: `nor_prog_seq`

## Requirements
- R1: An erase issues exactly six writes in this order: 0xAA at base+0x555, 0x55 at base+0x2AA, 0x80 at base+0x555, 0xAA at base+0x555, 0x55 at base+0x2AA, and 0x30 at the base. Polling follows, then one write of 0xF0 at the base.
- R2: For a program, each bank byte i is taken from the source when `src_valid` is high on a clock edge while a byte is awaited, and `src_ready` is high for the following cycle. Each byte issues four writes: 0xAA at base+0x555, 0x55 at base+0x2AA, 0xA0 at base+0x555, then the byte at base+i. A single 0xF0 at the base follows the last byte.
- R3: After every erase or byte program, the base address is read in pairs. The sequence moves on after the first pair whose two values are equal, and no other read comes between the operation and the read-back pass.
- R4: If POLL_LIMIT successive pairs all differ, the sequence ends with result code 1. No reset command is written and no read-back pass takes place.
- R5: After an erase, bytes base..base+BANK_BYTES-1 are read in ascending order. The first byte that is not 0xFF ends the sequence with code 2. If all bytes match, the code is 0.
- R6: After a program, bytes are read back in ascending order and compared with the bytes supplied. The first mismatch ends the sequence with code 3. If all bytes match, the code is 0.
- R7: Write enable stays low for exactly WE_CYC cycles, and output enable stays low for exactly RD_CYC cycles. The two are never low together. After a write, both stay high for at least SETTLE_CYC cycles before the next strobe.
- R8: `busy` rises the cycle after an accepted start and falls in the cycle where `done` pulses for exactly one cycle. `err_code` changes only at done, holds until the next accepted start, and is cleared by that start.
- R9: A start while busy is ignored: the running operation finishes unchanged and no extra operation follows.
- R10: Under reset, busy, done, err_code and src_ready are 0, and both flash strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken when idle |
| op_prog | input | 1 | 1 = program bank, 0 = erase bank |
| bank_base | input | AW | Bank base address |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | One-cycle acknowledge of a taken byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 timeout, 2 erase verify, 3 program verify |
| fl_addr | output | AW | Flash address |
| fl_dout | output | 8 | Flash write data |
| fl_din | input | 8 | Flash read data |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
The hardest situations to reach are the failure exits: a bit that never stops toggling, and a single bad byte deep inside the bank. The bench flash model has fault switches for both. One makes the status bit toggle forever. Another leaves one chosen byte un-erased. A third flips one bit of one programmed byte. Counting the model's reads then shows the exact number of poll pairs issued before the timeout and the exact byte at which the read-back stopped. A start pulse injected mid-erase, carrying a different base and mode, shows that nothing is retargeted.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_TIMEOUT   = 2'd1,
    ERR_ERASE_VFY = 2'd2,
    ERR_PROG_VFY  = 2'd3
  } seq_err_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CMD, S_POLL_A, S_POLL_B, S_RST, S_VFY, S_FIN
  } seq_state_e;

  typedef enum logic [1:0] {
    BE_IDLE, BE_WSTB, BE_WSET, BE_RACC
  } bus_state_e;

  localparam logic [7:0] CMD_UNLK_A   = 8'hAA;
  localparam logic [7:0] CMD_UNLK_B   = 8'h55;
  localparam logic [7:0] CMD_ERASE    = 8'h80;
  localparam logic [7:0] CMD_SECTOR   = 8'h30;
  localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
  localparam logic [7:0] CMD_RESET    = 8'hF0;
  localparam logic [10:0] OFS_UNLK_A  = 11'h555;
  localparam logic [10:0] OFS_UNLK_B  = 11'h2AA;
endpackage

// File: rtl/flash_bus_engine.sv
module flash_bus_engine
  import flash_seq_pkg::*;
#(
  parameter int AW         = 20,
  parameter int WE_CYC     = 4,
  parameter int RD_CYC     = 4,
  parameter int SETTLE_CYC = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_wdata,
  output logic          ack,
  output logic [7:0]    rdata,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dout,
  input  logic [7:0]    fl_din,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  localparam int MAX_AB = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
  localparam int MAXC   = (MAX_AB > SETTLE_CYC) ? MAX_AB : SETTLE_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  bus_state_e    st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= BE_IDLE;
      cnt     <= '0;
      ack     <= 1'b0;
      rdata   <= 8'h00;
      fl_addr <= '0;
      fl_dout <= 8'h00;
      fl_we_n <= 1'b1;
      fl_oe_n <= 1'b1;
    end else begin
      ack <= 1'b0;
      case (st)
        BE_IDLE: if (req) begin
          fl_addr <= req_addr;
          fl_dout <= req_wdata;
          cnt     <= '0;
          if (req_wr) begin
            fl_we_n <= 1'b0;
            st      <= BE_WSTB;
          end else begin
            fl_oe_n <= 1'b0;
            st      <= BE_RACC;
          end
        end
        BE_WSTB: if (cnt == CW'(WE_CYC - 1)) begin
          fl_we_n <= 1'b1;
          cnt     <= '0;
          st      <= BE_WSET;
        end else cnt <= cnt + 1'b1;
        BE_WSET: if (cnt == CW'(SETTLE_CYC - 1)) begin
          ack <= 1'b1;
          st  <= BE_IDLE;
        end else cnt <= cnt + 1'b1;
        BE_RACC: if (cnt == CW'(RD_CYC - 1)) begin
          rdata   <= fl_din;
          fl_oe_n <= 1'b1;
          ack     <= 1'b1;
          st      <= BE_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= BE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_step.sv
module flash_cmd_step
  import flash_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int IW = 8
) (
  input  logic          is_prog,
  input  logic [2:0]    step,
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] byte_idx,
  input  logic [7:0]    cur_byte,
  output logic [AW-1:0] addr,
  output logic [7:0]    data,
  output logic          last
);
  logic [AW-1:0] a_unlk_a, a_unlk_b;
  assign a_unlk_a = base + AW'(OFS_UNLK_A);
  assign a_unlk_b = base + AW'(OFS_UNLK_B);

  always_comb begin
    addr = a_unlk_a;
    data = CMD_UNLK_A;
    last = 1'b0;
    case (step)
      3'd1: begin addr = a_unlk_b; data = CMD_UNLK_B; end
      3'd2: data = is_prog ? CMD_PROGRAM : CMD_ERASE;
      3'd3: if (is_prog) begin
        addr = base + AW'(byte_idx);
        data = cur_byte;
        last = 1'b1;
      end
      3'd4: begin addr = a_unlk_b; data = CMD_UNLK_B; end
      3'd5: begin addr = base; data = CMD_SECTOR; last = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_data_buf.sv
module flash_data_buf #(
  parameter int DEPTH = 256,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] raddr,
  output logic [7:0]    q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/nor_prog_seq.sv
module nor_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int AW         = 20,
  parameter int BANK_BYTES = 256,
  parameter int WE_CYC     = 4,
  parameter int RD_CYC     = 4,
  parameter int SETTLE_CYC = 100,
  parameter int POLL_LIMIT = 1000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_prog,
  input  logic [AW-1:0] bank_base,
  input  logic          src_valid,
  input  logic [7:0]    src_data,
  output logic          src_ready,
  output logic          busy,
  output logic          done,
  output logic [1:0]    err_code,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dout,
  input  logic [7:0]    fl_din,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  localparam int IW = $clog2(BANK_BYTES);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(BANK_BYTES - 1);

  seq_state_e    st;
  logic [2:0]    step;
  logic [IW-1:0] idx;
  logic [PW-1:0] pcnt;
  logic [7:0]    first_rd, cur_byte, buf_q, vfy_exp;
  logic [AW-1:0] base_q;
  logic          is_prog, wait_ack;
  seq_err_e      err_pend;

  logic          bus_req, bus_wr, bus_ack;
  logic [AW-1:0] bus_addr, step_addr;
  logic [7:0]    bus_wdata, bus_rdata, step_data;
  logic          step_last, buf_we;

  flash_cmd_step #(.AW(AW), .IW(IW)) step_i (
    .is_prog(is_prog), .step(step), .base(base_q), .byte_idx(idx),
    .cur_byte(cur_byte), .addr(step_addr), .data(step_data), .last(step_last)
  );

  assign buf_we = (st == S_FETCH) && src_valid;

  flash_data_buf #(.DEPTH(BANK_BYTES), .IW(IW)) buf_i (
    .clk(clk), .we(buf_we), .waddr(idx), .wdata(src_data),
    .raddr(idx), .q(buf_q)
  );

  flash_bus_engine #(.AW(AW), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC),
                     .SETTLE_CYC(SETTLE_CYC)) bus_i (
    .clk(clk), .rst(rst), .req(bus_req), .req_wr(bus_wr), .req_addr(bus_addr),
    .req_wdata(bus_wdata), .ack(bus_ack), .rdata(bus_rdata),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  always_comb begin
    bus_req   = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = base_q;
    bus_wdata = 8'h00;
    case (st)
      S_CMD: begin
        bus_req = !wait_ack; bus_wr = 1'b1;
        bus_addr = step_addr; bus_wdata = step_data;
      end
      S_POLL_A, S_POLL_B: bus_req = !wait_ack;
      S_RST: begin bus_req = !wait_ack; bus_wr = 1'b1; bus_wdata = CMD_RESET; end
      S_VFY: begin bus_req = !wait_ack; bus_addr = base_q + AW'(idx); end
      default: ;
    endcase
  end

  assign vfy_exp = is_prog ? buf_q : 8'hFF;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; step <= '0; idx <= '0; pcnt <= '0;
      first_rd <= 8'h00; cur_byte <= 8'h00; base_q <= '0;
      is_prog <= 1'b0; wait_ack <= 1'b0; err_pend <= ERR_NONE;
      busy <= 1'b0; done <= 1'b0; err_code <= 2'd0; src_ready <= 1'b0;
    end else begin
      done      <= 1'b0;
      src_ready <= 1'b0;
      if (bus_req) wait_ack <= 1'b1;
      if (bus_ack) wait_ack <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          busy <= 1'b1; err_code <= 2'd0; err_pend <= ERR_NONE;
          is_prog <= op_prog; base_q <= bank_base;
          idx <= '0; step <= '0; pcnt <= '0;
          st <= op_prog ? S_FETCH : S_CMD;
        end
        S_FETCH: if (src_valid) begin
          cur_byte <= src_data; src_ready <= 1'b1; step <= '0; st <= S_CMD;
        end
        S_CMD: if (bus_ack) begin
          if (step_last) begin st <= S_POLL_A; pcnt <= '0; end
          else step <= step + 1'b1;
        end
        S_POLL_A: if (bus_ack) begin first_rd <= bus_rdata; st <= S_POLL_B; end
        S_POLL_B: if (bus_ack) begin
          if ((bus_rdata ^ first_rd) == 8'h00) begin
            if (is_prog && idx != LAST_IDX) begin idx <= idx + 1'b1; st <= S_FETCH; end
            else begin idx <= '0; st <= S_RST; end
          end else if (pcnt == PW'(POLL_LIMIT - 1)) begin
            err_pend <= ERR_TIMEOUT; st <= S_FIN;
          end else begin
            pcnt <= pcnt + 1'b1; st <= S_POLL_A;
          end
        end
        S_RST: if (bus_ack) begin idx <= '0; st <= S_VFY; end
        S_VFY: if (bus_ack) begin
          if (bus_rdata != vfy_exp) begin
            err_pend <= is_prog ? ERR_PROG_VFY : ERR_ERASE_VFY; st <= S_FIN;
          end else if (idx == LAST_IDX) st <= S_FIN;
          else idx <= idx + 1'b1;
        end
        S_FIN: begin
          busy <= 1'b0; done <= 1'b1; err_code <= err_pend; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int WE_CYC = 4,
  parameter int RD_CYC = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [1:0] err_code,
  input logic       src_ready,
  input logic       fl_we_n,
  input logic       fl_oe_n
);
  logic [31:0] we_lo_cnt, oe_lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_lo_cnt <= '0;
      oe_lo_cnt <= '0;
    end else begin
      we_lo_cnt <= fl_we_n ? 32'd0 : we_lo_cnt + 32'd1;
      oe_lo_cnt <= fl_oe_n ? 32'd0 : oe_lo_cnt + 32'd1;
    end
  end

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_oe_n));
  // R7
  we_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> (we_lo_cnt == 32'(WE_CYC)));
  // R7
  oe_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_oe_n) |-> (oe_lo_cnt == 32'(RD_CYC)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (err_code != $past(err_code)) |-> (done || $past(start && !busy)));
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
  // R2
  src_ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    src_ready |-> busy);
  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && err_code == 2'd0 && !src_ready && fl_we_n && fl_oe_n));
endmodule

bind nor_prog_seq flash_seq_chk #(.WE_CYC(WE_CYC), .RD_CYC(RD_CYC)) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .err_code(err_code), .src_ready(src_ready), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
);

// File: tb/nor_prog_seq_tb_top.sv
module nor_prog_seq_tb_top;
  localparam int AW = 12, BANK = 16, WE_CYC = 2, RD_CYC = 2, SETTLE_CYC = 3, POLL = 20;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, op_prog = 1'b0;
  logic [AW-1:0] bank_base = '0;
  logic src_valid, src_ready, busy, done, fl_we_n, fl_oe_n;
  logic [7:0] src_data, fl_dout, fl_din;
  logic [1:0] err_code;
  logic [AW-1:0] fl_addr;

  always #5 clk = ~clk;

  nor_prog_seq #(.AW(AW), .BANK_BYTES(BANK), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC),
                 .SETTLE_CYC(SETTLE_CYC), .POLL_LIMIT(POLL)) dut_i (
    .clk(clk), .rst(rst), .start(start), .op_prog(op_prog), .bank_base(bank_base),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .busy(busy), .done(done), .err_code(err_code), .fl_addr(fl_addr),
    .fl_dout(fl_dout), .fl_din(fl_din), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  int n_chk = 0, n_err = 0, cyc = 0;

  // source
  logic [7:0] src_buf [BANK];
  int  sidx = 0;
  bit  src_en = 0;
  int  ready_seen = 0;
  assign src_valid = src_en && (sidx < BANK);
  assign src_data  = src_buf[sidx % BANK];

  // flash model
  logic [7:0] mem [1 << AW];
  int  cs = 0, busy_rd = 0, wr_cnt = 0, rd_cnt = 0, f0_cnt = 0, proto = 0;
  int  last_f0_addr = -1, last_er_addr = -1;
  bit  tgl = 0, stuck = 0;
  int  er_bad = -1, pg_bad = -1;
  bit  we_q = 1, oe_q = 1, after_wr = 0;
  int  we_run = 0, oe_run = 0, gap = 0, we_bad = 0, oe_bad = 0, set_bad = 0, excl_bad = 0;

  assign fl_din = (busy_rd > 0 || stuck) ? {1'b0, tgl, 6'b0} : mem[fl_addr];

  initial for (int i = 0; i < (1 << AW); i++) mem[i] = 8'(i) ^ 8'h5A;

  always @(negedge clk) begin
    logic [10:0] lo;
    lo = fl_addr[10:0];
    cyc++;
    if (!fl_we_n && !fl_oe_n) excl_bad++;
    if ((we_q && !fl_we_n) || (oe_q && !fl_oe_n)) begin
      if (after_wr && gap < SETTLE_CYC) set_bad++;
      after_wr = 0;
    end
    if (!fl_we_n) we_run++;
    else if (!we_q) begin
      if (we_run != WE_CYC) we_bad++;
      we_run = 0; gap = 1; after_wr = 1;
      wr_cnt++;
      if (busy_rd > 0) proto++;
      case (cs)
        0: if (fl_dout == 8'hF0) begin f0_cnt++; last_f0_addr = int'(fl_addr); end
           else if (lo == 11'h555 && fl_dout == 8'hAA) cs = 1;
           else proto++;
        1: if (lo == 11'h2AA && fl_dout == 8'h55) cs = 2; else begin proto++; cs = 0; end
        2: if (lo == 11'h555 && fl_dout == 8'h80) cs = 3;
           else if (lo == 11'h555 && fl_dout == 8'hA0) cs = 6;
           else begin proto++; cs = 0; end
        3: if (lo == 11'h555 && fl_dout == 8'hAA) cs = 4; else begin proto++; cs = 0; end
        4: if (lo == 11'h2AA && fl_dout == 8'h55) cs = 5; else begin proto++; cs = 0; end
        5: begin
          if (fl_dout == 8'h30) begin
            last_er_addr = int'(fl_addr);
            for (int j = 0; j < BANK; j++)
              mem[int'(fl_addr) + j] = (j == er_bad) ? 8'h00 : 8'hFF;
            busy_rd = 4;
          end else proto++;
          cs = 0;
        end
        6: begin
          mem[fl_addr] = (int'(fl_addr) == pg_bad) ? (fl_dout ^ 8'h01) : (mem[fl_addr] & fl_dout);
          busy_rd = 4; cs = 0;
        end
        default: cs = 0;
      endcase
    end
    if (!fl_oe_n) oe_run++;
    else if (!oe_q) begin
      if (oe_run != RD_CYC) oe_bad++;
      oe_run = 0; rd_cnt++;
      if (stuck || busy_rd > 0) tgl = ~tgl;
      if (busy_rd > 0) busy_rd--;
    end
    if (fl_we_n && fl_oe_n && we_q) gap++;
    we_q = fl_we_n; oe_q = fl_oe_n;
    if (src_ready) begin sidx++; ready_seen++; end
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Launch an operation and wait for done; returns result code.
  task automatic run_op(input bit prog, input int base, input string tag, output int res);
    int lim;
    sidx = 0; src_en = prog;
    @(negedge clk);
    start = 1; op_prog = prog; bank_base = AW'(base);
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, {tag, " R8 busy after start"}, int'(busy), 1);
    lim = 0;
    while (!done && lim < 20000) begin @(negedge clk); lim++; end
    chk(done && !busy, {tag, " R8 done pulse with busy low"}, int'(done), 1);
    res = int'(err_code);
    src_en = 0;
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && err_code == 0 && !src_ready && fl_we_n && fl_oe_n,
        "R10 reset state", int'({busy, done, err_code, src_ready}), 0);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic t_erase(input int base);
    int w0 = wr_cnt, r0 = rd_cnt, f0 = f0_cnt, p0 = proto, res, bad = 0;
    run_op(0, base, "erase", res);
    chk(res == 0, "R5 erase ok code", res, 0);
    chk(wr_cnt - w0 == 7, "R1 erase write count", wr_cnt - w0, 7);
    chk(proto == p0 && last_er_addr == base, "R1 erase sequence/addr", last_er_addr, base);
    chk(f0_cnt - f0 == 1 && last_f0_addr == base, "R1 reset at base", last_f0_addr, base);
    chk(rd_cnt - r0 == 6 + BANK, "R3 erase poll+verify reads", rd_cnt - r0, 6 + BANK);
    for (int i = 0; i < BANK; i++) if (mem[base + i] != 8'hFF) bad++;
    chk(bad == 0, "R1 bank erased", bad, 0);
  endtask

  task automatic t_prog(input int base, input int seed);
    int w0 = wr_cnt, r0 = rd_cnt, p0 = proto, q0 = ready_seen, res, bad = 0;
    for (int i = 0; i < BANK; i++) src_buf[i] = 8'(i * seed + 5);
    run_op(1, base, "prog", res);
    chk(res == 0, "R6 program ok code", res, 0);
    chk(wr_cnt - w0 == 4 * BANK + 1, "R2 program write count", wr_cnt - w0, 4 * BANK + 1);
    chk(proto == p0, "R2 program sequence", proto - p0, 0);
    chk(ready_seen - q0 == BANK, "R2 bytes taken", ready_seen - q0, BANK);
    chk(rd_cnt - r0 == 6 * BANK + BANK, "R3 program poll+verify reads", rd_cnt - r0, 7 * BANK);
    for (int i = 0; i < BANK; i++) if (mem[base + i] != src_buf[i]) bad++;
    chk(bad == 0, "R2 bank contents", bad, 0);
  endtask

  task automatic t_timeout();
    int w0 = wr_cnt, r0 = rd_cnt, f0 = f0_cnt, res;
    stuck = 1;
    run_op(0, 'h800, "timeout", res);
    stuck = 0;
    chk(res == 1, "R4 timeout code", res, 1);
    chk(rd_cnt - r0 == 2 * POLL, "R4 poll pair count", rd_cnt - r0, 2 * POLL);
    chk(f0_cnt == f0 && wr_cnt - w0 == 6, "R4 no reset write", f0_cnt - f0, 0);
  endtask

  task automatic t_erase_vfy();
    int r0 = rd_cnt, res;
    er_bad = 5;
    run_op(0, 'h000, "erase_vfy", res);
    er_bad = -1;
    chk(res == 2, "R5 erase verify code", res, 2);
    chk(rd_cnt - r0 == 6 + 6, "R5 stops at first bad byte", rd_cnt - r0, 12);
    repeat (5) @(negedge clk);
    chk(err_code == 2, "R8 code held", int'(err_code), 2);
    @(negedge clk);
    start = 1; op_prog = 0; bank_base = AW'('h000);
    @(negedge clk);
    start = 0;
    chk(err_code == 0, "R8 code cleared by start", int'(err_code), 0);
    while (!done) @(negedge clk);
  endtask

  task automatic t_prog_vfy();
    int r0, res;
    t_erase('h800);
    r0 = rd_cnt;
    for (int i = 0; i < BANK; i++) src_buf[i] = 8'(8'hC3 ^ i);
    pg_bad = 'h800 + 9;
    run_op(1, 'h800, "prog_vfy", res);
    pg_bad = -1;
    chk(res == 3, "R6 program verify code", res, 3);
    chk(rd_cnt - r0 == 6 * BANK + 10, "R6 stops at first bad byte", rd_cnt - r0, 6 * BANK + 10);
  endtask

  task automatic t_busy_start();
    int w0 = wr_cnt, q0 = ready_seen, res;
    sidx = 0; src_en = 0;
    @(negedge clk);
    start = 1; op_prog = 0; bank_base = AW'('h000);
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    start = 1; op_prog = 1; bank_base = AW'('h800);
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    res = int'(err_code);
    chk(res == 0 && last_er_addr == 0, "R9 erase unaffected", last_er_addr, 0);
    repeat (60) @(negedge clk);
    chk(!busy && wr_cnt - w0 == 7, "R9 no extra operation", wr_cnt - w0, 7);
    chk(ready_seen == q0, "R9 no bytes taken", ready_seen - q0, 0);
  endtask

  initial begin
    t_reset();
    t_erase('h800);
    t_prog('h800, 37);
    t_erase('h000);
    t_prog('h000, 91);
    t_timeout();
    t_erase_vfy();
    t_prog_vfy();
    t_busy_start();
    chk(we_bad == 0 && oe_bad == 0, "R7 strobe widths", we_bad + oe_bad, 0);
    chk(set_bad == 0, "R7 settle gap", set_bad, 0);
    chk(excl_bad == 0, "R7 strobes exclusive", excl_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule